// File: doc/BRIEF.md
# Prefetching Instruction Fetch Stage with Control-Transfer Hold

This block is the front end of a simple in-order integer pipeline. A prefetch program counter, separate from the architectural PC, drives sequential word reads from instruction memory. The memory returns each word one cycle after its request. Fetched words reach the decode stage through a one-entry output buffer. A one-entry prefetch slot behind that buffer lets fetch run one instruction ahead.

Fetch does not predict. When a branch or jump lands in the output buffer, the stage stops issuing requests and enters a held state. It stays there until the late memory-access stage sends a resolution: a taken flag plus the resolved PC, counted in instructions. A taken resolution throws away whatever was fetched behind the control instruction, including a word still in flight, and restarts at the resolved PC. A not-taken resolution keeps the prefetched word and carries on sequentially.

Because of this look-ahead, a program must end with at least one padding instruction after its last real one.

Top module: `pfetch_unit`

## Requirements
- R1: While reset is asserted and just after it is released, the prefetch PC is 0: the first request goes to address 0, the stage reports Void and `dec_valid` is low.
- R2: Without control transfers or decode stalls, requests go to consecutive addresses. Decode receives each word with its address in address order, and after the first word one instruction arrives every cycle.
- R3: A word is a control instruction when bits [31:26] hold a value from 1 to 7, or when bits [31:26] are 0 and bits [5:0] are 8 or 9. Every other word, for example bits [31:26] = 0 with bits [5:0] = 32, or bits [31:26] = 8, flows on without holding.
- R4: Once a control instruction enters the output buffer, the stage reports Held. Until a resolution arrives it issues no request and delivers no later instruction.
- R5: A taken resolution while Held discards the prefetched word. The very next request goes to the resolved PC, and the next instruction decode sees is the one at that address.
- R6: A not-taken resolution while Held releases the hold and ignores the resolved PC. The word after the control instruction is delivered next, followed by its sequential successors.
- R7: A resolution that arrives while the stage is not Held has no effect on the state or on the instruction stream.
- R8: While decode holds off (`dec_hold` high with `dec_valid` high), the buffered instruction and its PC stay stable. Requests stop once the prefetch slot is full, and on release the stream resumes with no loss and no duplication.
- R9: `fetch_state` encodes Void = 0 (no valid instruction for decode), Active = 1 (valid instruction, not held) and Held = 2. Held takes precedence, and `dec_valid` marks an empty buffer rather than a substituted no-op.
- R10: A taken resolution that arrives while the word after the control instruction is still in flight from memory drops that word as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_req | output | 1 | Instruction read request |
| imem_addr | output | PC_W | Instruction address (instruction units) |
| imem_rdata | input | 32 | Read data, valid the cycle after a request |
| dec_valid | output | 1 | Output buffer holds an instruction |
| dec_instr | output | 32 | Instruction for decode |
| dec_pc | output | PC_W | Address of `dec_instr` |
| dec_hold | input | 1 | Decode cannot accept this cycle |
| res_valid | input | 1 | Control-transfer resolution present |
| res_taken | input | 1 | PC changed by other than a normal increment |
| res_pc | input | PC_W | Resolved PC |
| fetch_state | output | 2 | 0 Void, 1 Active, 2 Held |

## Verification
The hardest case to reach is a taken resolution that lands while the word behind the control instruction is still on its way back from memory. The pipeline only reaches that state in the single cycle after the branch enters the buffer. The bench gets there by watching the decode port and driving the resolution in the same half-cycle that the branch first appears. It then checks that the next request goes to the resolved address and that the word after the branch never shows up at decode. Decode stalls, and resolutions sent while the stage is not held, are likewise timed against a visible instruction, so that their effect on the stream can be pinned to one cycle.

// File: rtl/pfetch_pkg.sv
package pfetch_pkg;

  localparam int INSTR_W = 32;

  typedef enum logic [1:0] {
    ST_VOID   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_HELD   = 2'd2
  } fstate_e;

  // Control-transfer classification from the major opcode and function field.
  function automatic logic is_ctrl(input logic [5:0] op, input logic [5:0] fn);
    logic regular;
    logic reg_jump;
    regular  = (op >= 6'd1) && (op <= 6'd7);
    reg_jump = (op == 6'd0) && ((fn == 6'd8) || (fn == 6'd9));
    return regular || reg_jump;
  endfunction

endpackage

// File: rtl/pfetch_slot.sv
module pfetch_slot #(
  parameter int PC_W    = 10,
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               clear,
  input  logic [INSTR_W-1:0] d_instr,
  input  logic [PC_W-1:0]    d_pc,
  output logic               q_valid,
  output logic [INSTR_W-1:0] q_instr,
  output logic [PC_W-1:0]    q_pc
);

  logic valid_n;

  always_comb begin
    valid_n = q_valid;
    if (load)       valid_n = 1'b1;
    else if (clear) valid_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_valid <= 1'b0;
    else        q_valid <= valid_n;
  end

  // Payload registers carry no reset; valid qualifies them.
  always_ff @(posedge clk) begin
    if (load) begin
      q_instr <= d_instr;
      q_pc    <= d_pc;
    end
  end

endmodule

// File: rtl/pfetch_pc.sv
module pfetch_pc #(
  parameter int PC_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic            redirect,
  input  logic [PC_W-1:0] redirect_pc,
  output logic [PC_W-1:0] ppc,
  output logic            rsp_pending,
  output logic [PC_W-1:0] rsp_pc
);

  logic [PC_W-1:0] ppc_n;

  always_comb begin
    ppc_n = ppc;
    if (redirect)   ppc_n = redirect_pc;
    else if (issue) ppc_n = ppc + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppc         <= '0;
      rsp_pending <= 1'b0;
    end else begin
      ppc         <= ppc_n;
      rsp_pending <= issue;
    end
  end

  always_ff @(posedge clk) begin
    if (issue) rsp_pc <= ppc;
  end

endmodule

// File: rtl/pfetch_unit.sv
module pfetch_unit #(
  parameter int PC_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            imem_req,
  output logic [PC_W-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic            dec_valid,
  output logic [31:0]     dec_instr,
  output logic [PC_W-1:0] dec_pc,
  input  logic            dec_hold,
  input  logic            res_valid,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_pc,
  output logic [1:0]      fetch_state
);
  import pfetch_pkg::*;

  localparam int IW = pfetch_pkg::INSTR_W;

  logic            held, held_n;
  logic            squash, release_hold, rsp_ok;
  logic            issue;
  logic [PC_W-1:0] ppc, rsp_pc;
  logic            rsp_pending;

  logic            pf_valid, pf_load, pf_clear, pf_valid_n;
  logic [IW-1:0]   pf_instr;
  logic [PC_W-1:0] pf_pc;

  logic            ib_valid, ib_load, ib_clear, ib_free;
  logic [IW-1:0]   ib_instr;
  logic [PC_W-1:0] ib_pc;

  logic            src_valid;
  logic [IW-1:0]   src_instr;
  logic [PC_W-1:0] src_pc;
  fstate_e         st;

  // Resolution handling: only meaningful while held.
  assign release_hold = held && res_valid;
  assign squash       = release_hold && res_taken;
  assign rsp_ok       = rsp_pending && !squash;

  // Source feeding the output buffer: older prefetched word first.
  assign src_valid = pf_valid || rsp_ok;
  assign src_instr = pf_valid ? pf_instr : imem_rdata;
  assign src_pc    = pf_valid ? pf_pc    : rsp_pc;

  assign ib_free  = !ib_valid || !dec_hold;
  assign ib_load  = src_valid && !held && ib_free;
  assign ib_clear = ib_valid && !dec_hold;

  assign pf_load    = rsp_ok && !pf_valid && !ib_load;
  assign pf_clear   = squash || (pf_valid && ib_load);
  assign pf_valid_n = pf_load || (pf_valid && !pf_clear);

  // One word ahead at most: request only when the slot will be free.
  assign issue = !held && !pf_valid_n;

  always_comb begin
    held_n = held;
    if (release_hold)
      held_n = 1'b0;
    else if (ib_load && is_ctrl(src_instr[31:26], src_instr[5:0]))
      held_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= held_n;
  end

  pfetch_pc #(.PC_W(PC_W)) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (issue),
    .redirect    (squash),
    .redirect_pc (res_pc),
    .ppc         (ppc),
    .rsp_pending (rsp_pending),
    .rsp_pc      (rsp_pc)
  );

  pfetch_slot #(.PC_W(PC_W), .INSTR_W(IW)) u_pf (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (pf_load),
    .clear   (pf_clear),
    .d_instr (imem_rdata),
    .d_pc    (rsp_pc),
    .q_valid (pf_valid),
    .q_instr (pf_instr),
    .q_pc    (pf_pc)
  );

  pfetch_slot #(.PC_W(PC_W), .INSTR_W(IW)) u_ib (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ib_load),
    .clear   (ib_clear),
    .d_instr (src_instr),
    .d_pc    (src_pc),
    .q_valid (ib_valid),
    .q_instr (ib_instr),
    .q_pc    (ib_pc)
  );

  always_comb begin
    if (held)          st = ST_HELD;
    else if (ib_valid) st = ST_ACTIVE;
    else               st = ST_VOID;
  end

  assign imem_req    = issue;
  assign imem_addr   = ppc;
  assign dec_valid   = ib_valid;
  assign dec_instr   = ib_instr;
  assign dec_pc      = ib_pc;
  assign fetch_state = st;

endmodule

// File: rtl/pfetch_unit_chk.sv
module pfetch_unit_chk #(
  parameter int PC_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            imem_req,
  input logic [PC_W-1:0] imem_addr,
  input logic            dec_valid,
  input logic [31:0]     dec_instr,
  input logic [PC_W-1:0] dec_pc,
  input logic            dec_hold,
  input logic            res_valid,
  input logic            res_taken,
  input logic [PC_W-1:0] res_pc,
  input logic [1:0]      fetch_state
);
  import pfetch_pkg::*;

  // R4
  held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_state == ST_HELD) |-> !imem_req);

  // R5
  taken_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken && fetch_state == ST_HELD)
      |=> (imem_req && imem_addr == $past(res_pc)));

  // R6
  not_taken_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken && fetch_state == ST_HELD)
      |=> (fetch_state != ST_HELD));

  // R8
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_hold)
      |=> (dec_valid && $stable(dec_instr) && $stable(dec_pc)));

  // R2
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && imem_req && $past(imem_req))
      |-> (imem_addr == $past(imem_addr) + PC_W'(1)));

  // R7
  stray_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && fetch_state != ST_HELD && imem_req)
      |=> (!imem_req || imem_addr == $past(imem_addr) + PC_W'(1)));

endmodule

bind pfetch_unit pfetch_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .imem_req    (imem_req),
  .imem_addr   (imem_addr),
  .dec_valid   (dec_valid),
  .dec_instr   (dec_instr),
  .dec_pc      (dec_pc),
  .dec_hold    (dec_hold),
  .res_valid   (res_valid),
  .res_taken   (res_taken),
  .res_pc      (res_pc),
  .fetch_state (fetch_state)
);

// File: tb/pfetch_unit_bench.sv
`timescale 1ns/1ps
module pfetch_unit_bench;

  localparam int PC_W = 10;

  logic            clk;
  logic            rst_n;
  logic            imem_req;
  logic [PC_W-1:0] imem_addr;
  logic [31:0]     imem_rdata;
  logic            dec_valid;
  logic [31:0]     dec_instr;
  logic [PC_W-1:0] dec_pc;
  logic            dec_hold;
  logic            res_valid;
  logic            res_taken;
  logic [PC_W-1:0] res_pc;
  logic [1:0]      fetch_state;

  logic [31:0] mem [64];
  int checks = 0;
  int errors = 0;

  pfetch_unit #(.PC_W(PC_W)) u_pfetch_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .imem_req    (imem_req),
    .imem_addr   (imem_addr),
    .imem_rdata  (imem_rdata),
    .dec_valid   (dec_valid),
    .dec_instr   (dec_instr),
    .dec_pc      (dec_pc),
    .dec_hold    (dec_hold),
    .res_valid   (res_valid),
    .res_taken   (res_taken),
    .res_pc      (res_pc),
    .fetch_state (fetch_state)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Instruction memory model: data one cycle after the request.
  always_ff @(posedge clk) begin
    if (imem_req) imem_rdata <= mem[imem_addr[5:0]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_program();
    for (int i = 0; i < 64; i++) mem[i] = {6'h08, 10'h000, 16'(i)};
  endtask

  task automatic apply_reset();
    rst_n     = 1'b0;
    dec_hold  = 1'b0;
    res_valid = 1'b0;
    res_taken = 1'b0;
    res_pc    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic expect_next(input int exp_pc, input string req, output int waited);
    waited = 0;
    while (!dec_valid && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    chk({req, " valid"}, 32'(dec_valid), 32'd1);
    chk({req, " pc"}, 32'(dec_pc), 32'(exp_pc));
    chk({req, " instr"}, dec_instr, mem[exp_pc]);
    @(negedge clk);
  endtask

  task automatic check_held_idle(input string req);
    for (int i = 0; i < 3; i++) begin
      chk({req, " state held"}, 32'(fetch_state), 32'd2);
      chk({req, " no request"}, 32'(imem_req), 32'd0);
      chk({req, " nothing delivered"}, 32'(dec_valid), 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic resolve(input logic taken, input int pc);
    res_valid = 1'b1;
    res_taken = taken;
    res_pc    = PC_W'(pc);
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic t_reset();
    load_program();
    apply_reset();
    chk("R1 first request", 32'(imem_req), 32'd1);
    chk("R1 address zero", 32'(imem_addr), 32'd0);
    chk("R9 void state", 32'(fetch_state), 32'd0);
    chk("R9 no valid", 32'(dec_valid), 32'd0);
  endtask

  task automatic t_sequential();
    int w;
    load_program();
    mem[1] = {6'h00, 20'h00000, 6'h20};  // R3: non-control register op
    apply_reset();
    expect_next(0, "R2 seq", w);
    for (int p = 1; p < 8; p++) begin
      expect_next(p, "R2 seq", w);
      chk("R2 back-to-back", 32'(w), 32'd0);
    end
    chk("R9 active state", 32'(fetch_state), 32'd1);
  endtask

  task automatic t_stall();
    int w;
    load_program();
    apply_reset();
    expect_next(0, "R8 pre", w);
    expect_next(1, "R8 pre", w);
    dec_hold = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 held valid", 32'(dec_valid), 32'd1);
      chk("R8 held pc", 32'(dec_pc), 32'd2);
    end
    chk("R8 requests stop", 32'(imem_req), 32'd0);
    dec_hold = 1'b0;
    for (int p = 2; p < 6; p++) expect_next(p, "R8 resume", w);
  endtask

  task automatic t_taken();
    int w;
    load_program();
    mem[3] = {6'h04, 10'h000, 16'h0003};  // conditional branch
    apply_reset();
    for (int p = 0; p < 4; p++) expect_next(p, "R4 lead-in", w);
    check_held_idle("R4");
    resolve(1'b1, 40);
    chk("R5 redirect request", 32'(imem_req), 32'd1);
    chk("R5 redirect address", 32'(imem_addr), 32'd40);
    expect_next(40, "R5 target", w);
    expect_next(41, "R5 target", w);
  endtask

  task automatic t_not_taken();
    int w;
    load_program();
    mem[3] = {6'h05, 10'h000, 16'h0003};
    apply_reset();
    for (int p = 0; p < 4; p++) expect_next(p, "R6 lead-in", w);
    check_held_idle("R6");
    resolve(1'b0, 50);
    chk("R6 released", 32'(fetch_state == 2'd2), 32'd0);
    for (int p = 4; p < 7; p++) expect_next(p, "R6 fall-through", w);
  endtask

  task automatic t_ignore();
    int w;
    load_program();
    apply_reset();
    expect_next(0, "R7 pre", w);
    expect_next(1, "R7 pre", w);
    dec_hold = 1'b1;
    resolve(1'b1, 30);
    chk("R7 state unchanged", 32'(fetch_state), 32'd1);
    dec_hold = 1'b0;
    for (int p = 2; p < 5; p++) expect_next(p, "R7 stream", w);
  endtask

  task automatic t_classify();
    int w;
    load_program();
    mem[1]  = {6'h00, 20'h00000, 6'h20};        // register op, not control
    mem[2]  = {6'h00, 5'd1, 15'h0000, 6'h08};   // register jump
    mem[11] = {6'h01, 10'h000, 16'h000b};       // sign-test branch group
    apply_reset();
    expect_next(0, "R3 lead-in", w);
    expect_next(1, "R3 register op", w);
    chk("R3 register op no hold", 32'(w), 32'd0);
    expect_next(2, "R3 register jump", w);
    check_held_idle("R3 register jump");
    resolve(1'b1, 10);
    expect_next(10, "R3 after jump", w);
    expect_next(11, "R3 sign branch", w);
    check_held_idle("R3 sign branch");
    resolve(1'b0, 99);
    expect_next(12, "R3 after branch", w);
  endtask

  task automatic t_early();
    int w;
    load_program();
    mem[3] = {6'h04, 10'h000, 16'h0003};
    apply_reset();
    for (int p = 0; p < 3; p++) expect_next(p, "R10 lead-in", w);
    chk("R10 branch visible", 32'(dec_valid), 32'd1);
    chk("R10 branch pc", 32'(dec_pc), 32'd3);
    resolve(1'b1, 50);
    chk("R10 redirect request", 32'(imem_req), 32'd1);
    chk("R10 redirect address", 32'(imem_addr), 32'd50);
    expect_next(50, "R10 target", w);
    expect_next(51, "R10 target", w);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_sequential();
    t_stall();
    t_taken();
    t_not_taken();
    t_ignore();
    t_classify();
    t_early();
    finish_run();
  end

endmodule